// File: doc/BRIEF.md
# Posted-Write Gate with I/O Ordering

This block sits between a simple in-order core and a single external bus. The core presents one operation at a time: a memory load, a memory store, an I/O read, an I/O write or a serializing barrier. The block takes the operation on a cycle where `op_valid` is high and `op_stall` is low. Memory stores are posted into a four-entry FIFO and retire to the bus in the background, so the core can keep issuing.

Addresses whose upper bits (above the local index) are all zero belong to a small local data array. Loads to that region complete locally on the next cycle and may pass stores still waiting in the FIFO. The youngest matching FIFO entry is forwarded in place of the array contents. Every other load goes to the bus behind all older stores. Stores to the local region are written through: they update the array when their bus cycle is acknowledged.

I/O accesses never enter the FIFO, and each class of I/O has its own issue rule. An I/O read waits for the FIFO to empty before it is taken. An I/O write is taken at once but blocks the next operation until it has completed. A serializing operation waits until nothing is buffered or in flight.

Top module: `post_wr_gate`

## Requirements
- R1: After reset the FIFO is empty, `bus_req` is low, `rd_valid` is low, and `op_stall` is low while no operation is presented.
- R2: A store (op_kind 2) is taken without stall while the FIFO has room. Buffered stores appear on the bus as writes (`bus_wr`=1, `bus_io`=0) in the order they were issued.
- R3: A store presented while four stores are buffered is stalled until an entry retires.
- R4: A load (op_kind 1) to a local address (addr[7:4]==0) is taken without stall even when stores are buffered. `rd_valid` and `rd_data` follow one cycle after it is taken.
- R5: A local load whose address matches buffered stores returns the data of the youngest match. Once the stores have retired, it returns the written-through array contents.
- R6: A non-local load is taken at once but reaches the bus only after every older store. Its bus data is returned on `rd_data` the cycle after `bus_ack`, and every later operation stalls until then.
- R7: An I/O read (op_kind 3) is stalled while any store is buffered. It then runs as a bus read with `bus_io`=1, and its data is returned as in R6.
- R8: An I/O write (op_kind 4) is taken without stall even while stores are buffered and is never buffered. It runs on the bus after those stores with `bus_io`=1 and `bus_wr`=1, and the next operation is not taken until its bus cycle has completed.
- R9: A serializing operation (op_kind 5) is not taken until no store is buffered and no bus cycle is outstanding.
- R10: Once raised, `bus_req` and the bus address, data and type fields hold steady until `bus_ack`. Only one transaction is in flight at a time.
- R11: Under a mixed operation stream, the sequence of bus transactions equals the program order of all stores, non-local loads and I/O operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented |
| op_kind | input | 3 | 0 none, 1 load, 2 store, 3 I/O read, 4 I/O write, 5 serialize |
| op_addr | input | AW | Operation address |
| op_wdata | input | DW | Store or I/O write data |
| op_stall | output | 1 | Operation not taken this cycle |
| rd_valid | output | 1 | Load or I/O read result valid |
| rd_data | output | DW | Result data |
| bus_req | output | 1 | Bus transaction requested |
| bus_wr | output | 1 | 1 write, 0 read |
| bus_io | output | 1 | 1 I/O space, 0 memory space |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_ack | input | 1 | Bus transaction complete |
| bus_rdata | input | DW | Bus read data, valid with `bus_ack` |

## Verification
`op_stall` is combinational on the presented operation, so the bench reads it one nanosecond after the falling edge on which it drives the operation. A local load result is due on the falling edge right after the rising edge that takes it. Bus read results are due one cycle after the edge that sees `bus_ack`, and the bench polls falling edges for them within a bounded window. The bus responder samples the request fields on falling edges and compares each transaction, as it is acknowledged, against a program-order queue that the tasks fill as they issue operations.

// File: rtl/post_wr_gate.sv
module post_wr_gate #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int LAW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          op_stall,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          bus_req,
  output logic          bus_wr,
  output logic          bus_io,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  localparam int PW     = $clog2(DEPTH);
  localparam int LWORDS = 1 << LAW;
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);
  localparam logic [2:0] K_LD = 3'd1, K_ST = 3'd2, K_IORD = 3'd3,
                         K_IOWR = 3'd4, K_SER = 3'd5;

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [DW-1:0] lmem   [LWORDS];
  logic [PW-1:0] head, tail;
  logic [PW:0]   cnt;
  logic          pend_v, pend_rd, pend_io;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;
  logic [DW-1:0] hit_dat;

  wire q_empty  = (cnt == '0);
  wire q_full   = (cnt == FULL);
  wire is_local = (op_addr[AW-1:LAW] == '0);
  wire ld_hit   = (op_kind == K_LD) & is_local;
  wire ld_miss  = (op_kind == K_LD) & ~is_local;

  assign op_stall = pend_v
                  | ((op_kind == K_ST) & q_full)
                  | (((op_kind == K_IORD) | (op_kind == K_SER)) & ~q_empty);
  wire accept = op_valid & ~op_stall;
  wire push   = accept & (op_kind == K_ST);
  wire to_pend = accept & (ld_miss | (op_kind == K_IORD) | (op_kind == K_IOWR));

  assign bus_req   = ~q_empty | pend_v;
  assign bus_wr    = q_empty ? ~pend_rd  : 1'b1;
  assign bus_io    = q_empty ? pend_io   : 1'b0;
  assign bus_addr  = q_empty ? pend_addr : q_addr[head];
  assign bus_wdata = q_empty ? pend_data : q_data[head];

  wire done      = bus_req & bus_ack;
  wire pop       = done & ~q_empty;
  wire pend_done = done & q_empty;
  wire head_local = (q_addr[head][AW-1:LAW] == '0);

  always_comb begin
    hit_dat = lmem[op_addr[LAW-1:0]];
    for (int i = 0; i < DEPTH; i++)
      if (((PW+1)'(i) < cnt) && (q_addr[head + PW'(i)] == op_addr))
        hit_dat = q_data[head + PW'(i)];
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[tail] <= op_addr;
      q_data[tail] <= op_wdata;
    end
    if (pop && head_local)
      lmem[q_addr[head][LAW-1:0]] <= q_data[head];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
      pend_v   <= 1'b0;
      pend_rd  <= 1'b0;
      pend_io  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
      if (pend_done) pend_v <= 1'b0;
      if (to_pend) begin
        pend_v    <= 1'b1;
        pend_rd   <= (op_kind != K_IOWR);
        pend_io   <= (op_kind != K_LD);
        pend_addr <= op_addr;
        pend_data <= op_wdata;
      end
      rd_valid <= (pend_done & pend_rd) | (accept & ld_hit);
      if (pend_done) rd_data <= bus_rdata;
      else if (accept & ld_hit) rd_data <= hit_dat;
    end
  end

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !bus_ack && op_valid && op_kind == K_ST) |=> (op_stall || !q_full));
  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr)
                               && $stable(bus_io) && $stable(bus_wdata)));
  // R7
  iord_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind == K_IORD) |=> (bus_req && bus_io && !bus_wr && bus_addr == $past(op_addr)));
  // R9
  ser_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind == K_SER) |-> !bus_req);
  // R6
  miss_behind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ld_miss && !q_empty && !bus_ack) |=> (bus_req && bus_wr && !bus_io));
  // R8
  iowr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind == K_IOWR) |=> (op_stall && bus_req));
endmodule

// File: tb/post_wr_gate_tb_top.sv
`timescale 1ns/1ps
module post_wr_gate_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_kind = 3'd0;
  logic [7:0] op_addr = '0;
  logic [15:0] op_wdata = '0;
  logic op_stall, rd_valid, bus_req, bus_wr, bus_io;
  logic [15:0] rd_data, bus_wdata;
  logic [7:0] bus_addr;
  logic bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;

  always #4 clk = ~clk;

  post_wr_gate dut_i (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_stall(op_stall), .rd_valid(rd_valid),
    .rd_data(rd_data), .bus_req(bus_req), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit hold = 1'b0;
  int lat_max = 0, wcnt = 0;
  bit e_wr [1024];
  bit e_io [1024];
  logic [7:0] e_addr [1024];
  logic [15:0] e_data [1024];
  int exp_n = 0, obs_n = 0;
  logic [15:0] mem_m [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 1'b0;
      wcnt = (lat_max > 0) ? int'($urandom % (lat_max + 1)) : 0;
    end else if (bus_req && !hold) begin
      if (wcnt > 0) wcnt--;
      else begin
        if (obs_n >= exp_n)
          chk(0, cur_req, "unexpected bus txn addr", bus_addr, 0);
        else begin
          chk(bus_wr == e_wr[obs_n] && bus_io == e_io[obs_n] && bus_addr == e_addr[obs_n]
              && (!bus_wr || bus_wdata == e_data[obs_n]), cur_req,
              "bus txn {wr,io,addr}", {bus_wr, bus_io, bus_addr},
              {e_wr[obs_n], e_io[obs_n], e_addr[obs_n]});
          obs_n++;
        end
        bus_rdata = {8'hA5, bus_addr};
        bus_ack = 1'b1;
      end
    end
  end

  task automatic expect_bus(input [2:0] k, input [7:0] a, input [15:0] d);
    bit goes = (k == 3'd2) || (k == 3'd3) || (k == 3'd4) || (k == 3'd1 && a[7:4] != 0);
    if (k == 3'd2 && a[7:4] == 0) mem_m[a[3:0]] = d;
    if (goes) begin
      e_wr[exp_n] = (k == 3'd2) || (k == 3'd4);
      e_io[exp_n] = (k == 3'd3) || (k == 3'd4);
      e_addr[exp_n] = a;
      e_data[exp_n] = d;
      exp_n++;
    end
  endtask

  task automatic send(input [2:0] k, input [7:0] a, input [15:0] d, output int st);
    expect_bus(k, a, d);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_addr = a; op_wdata = d;
    st = 0;
    #1;
    while (op_stall) begin st++; @(negedge clk); #1; end
    @(posedge clk); #1;
    op_valid = 1'b0; op_kind = 3'd0;
  endtask

  task automatic wait_rd(output logic [15:0] v, output bit got);
    got = 0; v = '0;
    for (int i = 0; i < 60 && !got; i++) begin
      @(negedge clk);
      if (rd_valid) begin got = 1; v = rd_data; end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (!bus_req && !bus_ack) break;
    end
  endtask

  task automatic check_hit(input [15:0] exp, input string req);
    @(negedge clk);
    chk(rd_valid === 1'b1 && rd_data === exp, req, "local load result", rd_data, exp);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    @(negedge clk); #1;
    chk(op_stall === 1'b0, "R1", "op_stall after reset", op_stall, 0);
    chk(bus_req === 1'b0, "R1", "bus_req after reset", bus_req, 0);
    chk(rd_valid === 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
  endtask

  task automatic t_store_order();
    int st;
    cur_req = "R2";
    hold = 1;
    send(3'd2, 8'h81, 16'h1111, st); chk(st == 0, "R2", "store stall", st, 0);
    send(3'd2, 8'h92, 16'h2222, st); chk(st == 0, "R2", "store stall", st, 0);
    send(3'd2, 8'h13, 16'h3333, st); chk(st == 0, "R2", "store stall", st, 0);
    hold = 0;
    drain();
    chk(obs_n == exp_n, "R2", "stores retired", obs_n, exp_n);
  endtask

  task automatic t_full();
    int st;
    logic [7:0] first;
    cur_req = "R3";
    hold = 1;
    for (int i = 0; i < 4; i++) begin
      send(3'd2, 8'hB0 + 8'(i), 16'h4000 + 16'(i), st);
      chk(st == 0, "R3", "store into non-full buffer stalled", st, 0);
    end
    expect_bus(3'd2, 8'hB4, 16'h4004);
    @(negedge clk);
    op_valid = 1; op_kind = 3'd2; op_addr = 8'hB4; op_wdata = 16'h4004;
    #1;
    chk(op_stall === 1'b1, "R3", "store into full buffer", op_stall, 1);
    first = bus_addr;
    chk(bus_req === 1'b1 && first == 8'hB0, "R10", "head on bus", first, 8'hB0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(op_stall === 1'b1, "R3", "full stall held", op_stall, 1);
      chk(bus_req === 1'b1 && bus_addr == first, "R10", "bus fields held", bus_addr, first);
    end
    hold = 0;
    while (op_stall) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    op_valid = 0; op_kind = 0;
    drain();
    chk(obs_n == exp_n, "R3", "all stores retired", obs_n, exp_n);
  endtask

  task automatic t_hit_bypass();
    int st;
    cur_req = "R4";
    send(3'd2, 8'h05, 16'h1234, st);
    drain();
    hold = 1;
    send(3'd2, 8'h80, 16'h5555, st);
    send(3'd1, 8'h05, 16'h0, st);
    chk(st == 0, "R4", "local load stalled behind store", st, 0);
    check_hit(16'h1234, "R4");
    hold = 0;
    drain();
  endtask

  task automatic t_forward();
    int st;
    cur_req = "R5";
    hold = 1;
    send(3'd2, 8'h05, 16'hAAAA, st);
    send(3'd2, 8'h05, 16'hBBBB, st);
    send(3'd2, 8'h06, 16'hCCCC, st);
    send(3'd1, 8'h05, 16'h0, st);
    chk(st == 0, "R5", "forwarding load stall", st, 0);
    check_hit(16'hBBBB, "R5");
    hold = 0;
    drain();
    send(3'd1, 8'h05, 16'h0, st);
    check_hit(16'hBBBB, "R5");
    send(3'd1, 8'h06, 16'h0, st);
    check_hit(16'hCCCC, "R5");
  endtask

  task automatic t_ldmiss();
    int st;
    logic [15:0] v;
    bit got;
    cur_req = "R6";
    hold = 1;
    send(3'd2, 8'h90, 16'h0909, st);
    send(3'd2, 8'h91, 16'h0919, st);
    send(3'd1, 8'hA0, 16'h0, st);
    chk(st == 0, "R6", "miss load taken", st, 0);
    @(negedge clk);
    op_valid = 1; op_kind = 3'd1; op_addr = 8'h05;
    #1;
    chk(op_stall === 1'b1, "R6", "op after miss load stalls", op_stall, 1);
    op_valid = 0; op_kind = 0;
    hold = 0;
    wait_rd(v, got);
    chk(got && v == 16'hA5A0, "R6", "miss load data", v, 16'hA5A0);
    chk(obs_n == exp_n, "R6", "miss after stores", obs_n, exp_n);
  endtask

  task automatic t_ioread();
    int st;
    logic [15:0] v;
    bit got;
    cur_req = "R7";
    hold = 1;
    send(3'd2, 8'h84, 16'h8484, st);
    fork
      send(3'd3, 8'h33, 16'h0, st);
      begin repeat (3) @(negedge clk); hold = 0; end
    join
    chk(st >= 3, "R7", "io read held while store buffered", st, 3);
    wait_rd(v, got);
    chk(got && v == 16'hA533, "R7", "io read data", v, 16'hA533);
    chk(obs_n == exp_n, "R7", "io read after store", obs_n, exp_n);
  endtask

  task automatic t_iowrite();
    int st, st2;
    cur_req = "R8";
    hold = 1;
    send(3'd2, 8'h85, 16'h8585, st);
    send(3'd4, 8'h40, 16'h7777, st);
    chk(st == 0, "R8", "io write taken at once", st, 0);
    fork
      send(3'd1, 8'h05, 16'h0, st2);
      begin repeat (3) @(negedge clk); hold = 0; end
    join
    chk(st2 > 0, "R8", "op after io write stalled", st2, 1);
    chk(obs_n == exp_n, "R8", "io write done before next op", obs_n, exp_n);
    check_hit(16'hBBBB, "R8");
  endtask

  task automatic t_serial();
    int st;
    cur_req = "R9";
    hold = 1;
    send(3'd2, 8'h86, 16'h8686, st);
    send(3'd2, 8'h87, 16'h8787, st);
    fork
      send(3'd5, 8'h00, 16'h0, st);
      begin repeat (4) @(negedge clk); hold = 0; end
    join
    chk(st >= 4, "R9", "serialize held", st, 4);
    chk(obs_n == exp_n, "R9", "drained at serialize", obs_n, exp_n);
  endtask

  task automatic t_random();
    int st;
    logic [15:0] v;
    bit got;
    cur_req = "R11";
    lat_max = 2;
    for (int i = 0; i < 16; i++) send(3'd2, 8'(i), 16'(16'hC000 + i), st);
    send(3'd5, 8'h00, 16'h0, st);
    for (int n = 0; n < 80; n++) begin
      int r = int'($urandom % 6);
      logic [7:0] a = ($urandom % 2) ? {4'h0, 4'($urandom)} : 8'($urandom | 32'h10);
      logic [15:0] d = 16'($urandom);
      case (r)
        0, 1: send(3'd2, a, d, st);
        2: begin
          send(3'd1, a, d, st);
          if (a[7:4] == 0) check_hit(mem_m[a[3:0]], "R11");
          else begin
            wait_rd(v, got);
            chk(got && v == {8'hA5, a}, "R11", "random miss data", v, {8'hA5, a});
          end
        end
        3: begin
          send(3'd3, a, d, st);
          wait_rd(v, got);
          chk(got && v == {8'hA5, a}, "R11", "random io read data", v, {8'hA5, a});
        end
        4: send(3'd4, a, d, st);
        default: send(3'd5, a, d, st);
      endcase
    end
    drain();
    chk(obs_n == exp_n, "R11", "all bus txns seen in order", obs_n, exp_n);
    lat_max = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_store_order();
    t_full();
    t_hit_bypass();
    t_forward();
    t_ldmiss();
    t_ioread();
    t_iowrite();
    t_serial();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule